// File: doc/BRIEF.md
# Shadow-Buffered Pulse-Width Generator

This block drives one pulse-width modulated output from a free-running up-counter. A small word-addressed register port holds a 16-bit control word and four 32-bit timing registers. Two of these, the live period and the live threshold, set the waveform that is being produced. The other two are staging copies. Software writes the next period and threshold into them while the output runs. The block copies them into the live pair only when the counter wraps, so the cycle that is running always finishes with the values it started with.

Three control bits shape the output. One lets the counter advance, one connects the comparator to the pin, and one swaps which part of each cycle the threshold describes. While the generator is stopped, the live registers can be written directly and take effect at once. Clearing the control word halts the counter and holds the pin low.

Top module: `aux_pwm_shadow`

## Requirements
- R1: After reset every register reads zero and the output is low.
- R2: Word reads return register contents: live period at byte 0x08, live threshold at 0x0C, staged period at 0x10, staged threshold at 0x14, and the 16-bit control word in bits 31:16 of the word at 0x28 (halfword 0x2A), all 16 bits stored. Any other address reads zero.
- R3: Byte enable i (bit i of the 4-bit enable) writes data bits 8i+7:8i only. Control bits 7:0 sit in lane 2 and bits 15:8 in lane 3.
- R4: While control bit 4 (run) is set, the counter steps from 0 up to the live period P and then returns to 0, so one output cycle lasts P+1 clocks.
- R5: With control bit 9 (output enable) set and bit 10 (invert) clear, the output is high while the count is below the live threshold C. Each cycle then has min(C, P+1) high clocks, and C > P gives a constant high.
- R6: With bit 10 set, the output is the complement, so each cycle has min(C, P+1) low clocks.
- R7: With bit 4 clear, the counter holds its value and the output stays constant.
- R8: With bit 9 clear, the output is driven low one clock later, whatever the state of the counter.
- R9: Writing a staged register leaves the live registers unchanged. The staged pair is copied into the live pair at the clock on which the counter wraps. Starting from count 0 with live period P, the copy appears P+1 clocks after the run bit is set.
- R10: A write to either staged register arms one pending transfer. Each wrap consumes it, so later wraps do not reload the live pair.
- R11: A direct write to a live register is visible on the next read and sets the waveform from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | AW | Byte address (word aligned) |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pwm_out | output | 1 | Registered pulse output |

## Verification
The waveform is swept over every period from 1 to 6, against thresholds from 0 to 8 and both polarities. Counting high clocks over whole cycles separates the zero-threshold, mid-cycle, threshold-equals-period and threshold-above-period cases. It also shows whether the comparator, the wrap point or the inversion is off by one. A separate sequence stages new values from a known count of 0 and times the copy to the exact clock. This tells an early or late transfer apart from a correct one. A later direct write then shows whether a stale pending flag reloads old staged values. Stop and disable patterns confirm that the halted counter freezes the pin and that the disable bit forces it low.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    localparam int unsigned TW = 32;
    localparam int unsigned CTW = 16;

    // word indices (byte offset >> 2)
    localparam int unsigned WI_PER_LIVE  = 2;
    localparam int unsigned WI_THR_LIVE  = 3;
    localparam int unsigned WI_PER_STAGE = 4;
    localparam int unsigned WI_THR_STAGE = 5;
    localparam int unsigned WI_CTRL      = 10;

    localparam int unsigned BIT_RUN = 4;
    localparam int unsigned BIT_EN  = 9;
    localparam int unsigned BIT_INV = 10;

    typedef struct packed {
        logic run;
        logic en;
        logic inv;
    } ctl_t;

    typedef struct packed {
        logic [TW-1:0] per;
        logic [TW-1:0] thr;
    } timing_t;

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = be[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
        return r;
    endfunction

    function automatic ctl_t decode_ctl(input logic [CTW-1:0] w);
        ctl_t c;
        c.run = w[BIT_RUN];
        c.en  = w[BIT_EN];
        c.inv = w[BIT_INV];
        return c;
    endfunction

endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
    import apwm_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [3:0]     bus_be,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    input  logic           wrap,
    output timing_t        live,
    output logic [CTW-1:0] ctl_word
);
    localparam int unsigned WIW = AW - 2;

    timing_t stage_q, live_q;
    logic [CTW-1:0] ctl_q;
    logic pend_q;

    logic [WIW-1:0] widx;
    logic wr, wr_pl, wr_tl, wr_ps, wr_ts, wr_ctl, xfer;
    logic [31:0] ctl_merged;

    assign widx   = bus_addr[AW-1:2];
    assign wr     = bus_sel && bus_we;
    assign wr_pl  = wr && (widx == WIW'(WI_PER_LIVE));
    assign wr_tl  = wr && (widx == WIW'(WI_THR_LIVE));
    assign wr_ps  = wr && (widx == WIW'(WI_PER_STAGE));
    assign wr_ts  = wr && (widx == WIW'(WI_THR_STAGE));
    assign wr_ctl = wr && (widx == WIW'(WI_CTRL));
    assign xfer   = wrap && pend_q;
    assign ctl_merged = lane_merge({ctl_q, 16'h0000}, bus_wdata, bus_be);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            live_q  <= '0;
            ctl_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (wr_ps) stage_q.per <= lane_merge(stage_q.per, bus_wdata, bus_be);
            if (wr_ts) stage_q.thr <= lane_merge(stage_q.thr, bus_wdata, bus_be);
            if (wr_ctl) ctl_q <= ctl_merged[31:16];
            // the wrap-time copy takes priority over a direct write in the same clock
            if (xfer) begin
                live_q <= stage_q;
            end else begin
                if (wr_pl) live_q.per <= lane_merge(live_q.per, bus_wdata, bus_be);
                if (wr_tl) live_q.thr <= lane_merge(live_q.thr, bus_wdata, bus_be);
            end
            if (wr_ps || wr_ts) pend_q <= 1'b1;
            else if (xfer)      pend_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if      (widx == WIW'(WI_PER_LIVE))  bus_rdata = live_q.per;
            else if (widx == WIW'(WI_THR_LIVE))  bus_rdata = live_q.thr;
            else if (widx == WIW'(WI_PER_STAGE)) bus_rdata = stage_q.per;
            else if (widx == WIW'(WI_THR_STAGE)) bus_rdata = stage_q.thr;
            else if (widx == WIW'(WI_CTRL))      bus_rdata = {ctl_q, 16'h0000};
        end
    end

    assign live     = live_q;
    assign ctl_word = ctl_q;

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !wr_pl) |=> $stable(live_q.per)) else $error("live period moved"); // R9
    AST_XFER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wrap && pend_q) |=> (live_q == $past(stage_q))) else $error("staged copy missed"); // R9
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (rst)
        (wrap && pend_q && !wr_ps && !wr_ts) |=> !pend_q) else $error("pending not consumed"); // R10
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter
    import apwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] per,
    output logic [TW-1:0] cnt,
    output logic          wrap
);
    logic [TW-1:0] cnt_q;

    // >= also recovers when the period is rewritten below the current count
    assign wrap = run && (cnt_q >= per);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else if (run)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_q >= per) |=> (cnt_q == '0)) else $error("no wrap"); // R4
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q)) else $error("counter moved while halted"); // R7
endmodule

// File: rtl/apwm_outgen.sv
module apwm_outgen
    import apwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic [TW-1:0] cnt,
    input  logic [TW-1:0] thr,
    output logic          pwm
);
    logic active_phase, pwm_q;

    assign active_phase = (cnt < thr);

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= ctl.en & (active_phase ^ ctl.inv);
    end

    assign pwm = pwm_q;

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !pwm_q) else $error("output not low when disabled"); // R8
endmodule

// File: rtl/aux_pwm_shadow.sv
module aux_pwm_shadow
    import apwm_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [3:0]    bus_be,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          pwm_out
);
    timing_t        live;
    logic [CTW-1:0] ctl_word;
    ctl_t           ctl;
    logic [TW-1:0]  cnt;
    logic           wrap;

    assign ctl = decode_ctl(ctl_word);

    apwm_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wrap(wrap), .live(live), .ctl_word(ctl_word)
    );

    apwm_counter u_cnt (
        .clk(clk), .rst(rst), .run(ctl.run), .per(live.per),
        .cnt(cnt), .wrap(wrap)
    );

    apwm_outgen u_out (
        .clk(clk), .rst(rst), .ctl(ctl), .cnt(cnt), .thr(live.thr),
        .pwm(pwm_out)
    );
endmodule

// File: tb/aux_pwm_shadow_tb.sv
module aux_pwm_shadow_tb;
    localparam int AW = 6;
    localparam logic [31:0] C_RUN = 32'h0010_0000;
    localparam logic [31:0] C_EN  = 32'h0200_0000;
    localparam logic [31:0] C_INV = 32'h0400_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic pwm_out;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    aux_pwm_shadow #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles exp < 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a[AW-1:0]; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_be = '0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a[AW-1:0];
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    initial begin
        logic [31:0] v;
        int h, k, exp_h, bad;
        logic v0;

        do_reset();
        // R1 reset state
        chk("R1 out", {31'b0, pwm_out}, 0);
        br(8'h08, v); chk("R1 per_live", v, 0);
        br(8'h0C, v); chk("R1 thr_live", v, 0);
        br(8'h10, v); chk("R1 per_stage", v, 0);
        br(8'h14, v); chk("R1 thr_stage", v, 0);
        br(8'h28, v); chk("R1 ctl", v, 0);

        // R2 map and unmapped read
        bw(8'h10, 32'h1234_5678, 4'hF); br(8'h10, v); chk("R2 stage per", v, 32'h1234_5678);
        bw(8'h14, 32'h0000_ABCD, 4'hF); br(8'h14, v); chk("R2 stage thr", v, 32'h0000_ABCD);
        br(8'h00, v); chk("R2 unmapped", v, 0);
        br(8'h08, v); chk("R2 live untouched", v, 0);

        // R3 byte lanes; all 16 control bits stored
        bw(8'h08, 32'hAABB_CCDD, 4'b0101); br(8'h08, v); chk("R3 lanes", v, 32'h00BB_00DD);
        bw(8'h28, 32'hFFFF_0000, 4'b0100); br(8'h28, v); chk("R3 ctl lane2", v, 32'h00FF_0000);
        bw(8'h28, 32'hFFFF_0000, 4'b1100); br(8'h28, v); chk("R2 ctl 16 bits", v, 32'hFFFF_0000);
        bw(8'h28, 32'h0, 4'b1100);

        // R11 direct live write while stopped
        bw(8'h08, 32'd5, 4'hF); br(8'h08, v); chk("R11 immediate", v, 5);

        // R4 R5 R6 R11 sweep: period 1..6, threshold 0..8, both polarities
        do_reset();
        for (int inv = 0; inv < 2; inv++) begin
            for (int p = 1; p <= 6; p++) begin
                for (int c = 0; c <= 8; c++) begin
                    bw(8'h28, 32'h0, 4'b1100);
                    bw(8'h08, p, 4'hF);
                    bw(8'h0C, c, 4'hF);
                    bw(8'h28, C_RUN | C_EN | (inv != 0 ? C_INV : 32'h0), 4'b1100);
                    repeat (p + 4) @(negedge clk);
                    count_high(2 * (p + 1), h);
                    exp_h = (c < p + 1) ? c : p + 1;
                    if (inv != 0) exp_h = (p + 1) - exp_h;
                    chk(inv != 0 ? "R6 low time" : "R5 R4 high time", h, 2 * exp_h);
                end
            end
        end

        // R9 staged values take effect at the wrap after P+1 clocks
        do_reset();
        bw(8'h08, 32'd9, 4'hF);
        bw(8'h0C, 32'd3, 4'hF);
        bw(8'h10, 32'd4, 4'hF);
        bw(8'h14, 32'd2, 4'hF);
        br(8'h08, v); chk("R9 live per held", v, 9);
        br(8'h0C, v); chk("R9 live thr held", v, 3);
        bw(8'h28, C_RUN | C_EN, 4'b1100);
        k = 0;
        do begin br(8'h08, v); k++; end while (v != 4 && k < 100);
        chk("R9 copy clock", k, 10);
        br(8'h0C, v); chk("R9 thr copied", v, 2);
        repeat (6) @(negedge clk);
        count_high(10, h); chk("R9 new waveform", h, 4);

        // R10 pending consumed: a direct write survives later wraps
        bw(8'h08, 32'd7, 4'hF);
        repeat (30) @(negedge clk);
        br(8'h08, v); chk("R10 no reload", v, 7);
        br(8'h0C, v); chk("R10 thr kept", v, 2);

        // R7 halt freezes output
        bw(8'h0C, 32'd4, 4'hF);
        bw(8'h28, C_EN, 4'b1100);
        repeat (2) @(negedge clk);
        v0 = pwm_out; bad = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out !== v0) bad++; end
        chk("R7 frozen", bad, 0);

        // R8 disable with counter running forces low
        bw(8'h0C, 32'd100, 4'hF);
        bw(8'h28, C_RUN | C_EN, 4'b1100);
        repeat (2) @(negedge clk);
        chk("R5 thr above period high", {31'b0, pwm_out}, 1);
        bw(8'h28, C_RUN | C_INV, 4'b1100);
        count_high(20, h); chk("R8 disabled low", h, 0);
        bw(8'h28, 32'h0, 4'b1100);
        count_high(10, h); chk("R8 stopped low", h, 0);

        finish_run();
    end
endmodule